// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a one-bit sample stream by a whole number of clock periods chosen by a 10-bit delay code. It is a cycle-based, synthesizable model of a fine-step delay element. A fixed base latency is always present. On top of it sits a chain of ten delay stages whose lengths are powers of two, and each code bit switches its stage into the path or around it. The block drives a true output and a separately registered complement output.

An active-low enable acts at the input. While it is high, every new sample enters the path as a zero. The forced state (true low, complement high) therefore reaches the outputs only after the programmed delay, and data already inside the path drains out first. The delay code is registered on every clock edge and steers the whole path at once. After a code change, the output follows the new delay once the path has been flushed.

Top module: `prog_delay_line`

## Requirements
- R1: While the internal reset is active, and for the first clock edges after `rst_ni` is released, `q_o` is 0 and `qn_o` is 1. All path registers clear on reset.
- R2: With code 0 the delay is BASE_LAT cycles. The value of `din_i` at rising edge k shows on `q_o` after edge k+BASE_LAT-1.
- R3: For a steady code C, the value of `din_i` at rising edge k shows on `q_o` after edge k+BASE_LAT+C-1. Code bit i (bit 0 is the LSB) adds 2^i cycles.
- R4: With all code bits set (1023), the delay is BASE_LAT+1023 cycles.
- R5: The delay is monotonic. Raising the code by one adds exactly one cycle, and this holds across the carry from 511 to 512.
- R6: A sample taken while `en_ni` is 1 enters the path as 0. After `en_ni` rises at edge k, `q_o` keeps showing earlier data through edge k+BASE_LAT+C-2 and reads 0 after edge k+BASE_LAT+C-1.
- R7: `qn_o` is the inverse of `q_o` in every cycle.
- R8: `code_i` is taken on every rising edge and applies to the whole path. Once a new code has been held for BASE_LAT+1026 cycles, the output follows R3 for that code.
- R9: Once `en_ni` has been 1 for BASE_LAT+1023 consecutive edges, `q_o` stays 0, even while the code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; one delay unit is one period |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| din_i | input | 1 | Data sample to be delayed |
| code_i | input | CODE_W (10) | Delay code; bit i selects a stage of 2^i cycles |
| en_ni | input | 1 | Active-low enable; when 1 the input is replaced by 0 |
| q_o | output | 1 | Delayed true output |
| qn_o | output | 1 | Delayed complement output |

## Verification
The hardest situation to reach is a drained path after a long disable while the code keeps switching. Only then do stale bits in the long stages, which are bypassed at one moment and selected the next, show whether they were really flushed. The stimulus holds the enable high for more than the longest path length. During that time it keeps changing the code, first every hundred or so cycles and then every ten cycles, and checks that the output stays low. The 511-to-512 carry is reached by measuring single-pulse delays on both codes after a full settle period. Random data with sparse disable pulses is then compared against a history model for a set of codes that includes both extremes.

// File: rtl/pdl_pkg.sv
`timescale 1ns/1ps
package pdl_pkg;
  localparam int unsigned DEF_CODE_W   = 10;
  localparam int unsigned DEF_BASE_LAT = 2;

  // length in cycles of the binary-weighted stage for code bit idx
  function automatic int unsigned stage_len(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

  // longest register path from input to output
  function automatic int unsigned max_latency(input int unsigned code_w,
                                              input int unsigned base_lat);
    return base_lat + (32'd1 << code_w) - 32'd1;
  endfunction
endpackage

// File: rtl/pdl_shift.sv
`timescale 1ns/1ps
module pdl_shift #(
  parameter int unsigned LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;

  generate
    if (LEN == 1) begin : g_single
      always_comb sr_d = d_i;
    end else begin : g_chain
      always_comb sr_d = {sr_q[LEN-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign q_o = sr_q[LEN-1];
endmodule

// File: rtl/pdl_bin_stage.sv
`timescale 1ns/1ps
module pdl_bin_stage #(
  parameter int unsigned IDX = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LEN = pdl_pkg::stage_len(IDX);

  logic tap;

  // the pipe always shifts, so a stage switched in later holds no stale data
  pdl_shift #(.LEN(LEN)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (d_i),
    .q_o    (tap)
  );

  assign q_o = sel_i ? tap : d_i;
endmodule

// File: rtl/prog_delay_line.sv
`timescale 1ns/1ps
module prog_delay_line #(
  parameter int unsigned CODE_W   = pdl_pkg::DEF_CODE_W,
  parameter int unsigned BASE_LAT = pdl_pkg::DEF_BASE_LAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              en_ni,
  output logic              q_o,
  output logic              qn_o
);
  localparam int unsigned FLUSH = pdl_pkg::max_latency(CODE_W, BASE_LAT);
  localparam int unsigned CNT_W = $clog2(FLUSH + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // input gating register (first base stage)
  logic in_d, in_q;
  always_comb in_d = en_ni ? 1'b0 : din_i;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) in_q <= 1'b0;
    else        in_q <= in_d;
  end

  // code register with explicit load enable
  logic [CODE_W-1:0] code_q;
  logic              code_ld;
  always_comb code_ld = (code_i != code_q);
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_ld) code_q <= code_i;
  end

  // remaining base latency (output register supplies the last cycle)
  logic base_tail;
  generate
    if (BASE_LAT > 2) begin : g_base_pipe
      pdl_shift #(.LEN(BASE_LAT - 2)) u_base (
        .clk_i  (clk_i),
        .rst_ni (rst_n),
        .d_i    (in_q),
        .q_o    (base_tail)
      );
    end else begin : g_base_direct
      assign base_tail = in_q;
    end
  endgenerate

  // binary-weighted stage chain
  logic [CODE_W:0] chain;
  assign chain[0] = base_tail;

  generate
    for (genvar gi = 0; gi < CODE_W; gi++) begin : g_stage
      pdl_bin_stage #(.IDX(gi)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_n),
        .sel_i  (code_q[gi]),
        .d_i    (chain[gi]),
        .q_o    (chain[gi+1])
      );
    end
  endgenerate

  // output registers, true and complement held separately
  logic q_d, qn_d, q_q, qn_q;
  always_comb begin
    q_d  = chain[CODE_W];
    qn_d = ~chain[CODE_W];
  end
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      q_q  <= 1'b0;
      qn_q <= 1'b1;
    end else begin
      q_q  <= q_d;
      qn_q <= qn_d;
    end
  end

  assign q_o  = q_q;
  assign qn_o = qn_q;

  // ---------------- assertions ----------------
  // disable-length window counter for the flush check
  logic [CNT_W-1:0] off_cnt;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                       off_cnt <= '0;
    else if (!en_ni)                  off_cnt <= '0;
    else if (off_cnt < CNT_W'(FLUSH)) off_cnt <= off_cnt + CNT_W'(1);
  end

  // R6: a disabled sample enters the path as zero
  a_r6_gate_input: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_ni |=> !in_q);

  // R7: the two output registers never agree
  a_r7_complement: assert property (@(posedge clk_i) disable iff (!rst_n)
    q_o != qn_o);

  // R2: with code 0 the output follows the base pipe by one register
  a_r2_zero_code_path: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(code_q) == '0) |-> (q_o == $past(base_tail)));

  // R9: after a full flush window of disable, the output stays low
  a_r9_flush_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    (off_cnt >= CNT_W'(FLUSH)) |-> !q_o);
endmodule

// File: tb/prog_delay_line_tb.sv
`timescale 1ns/1ps
module prog_delay_line_tb;
  localparam int CW     = 10;
  localparam int BL     = 2;
  localparam int HLEN   = 4096;
  localparam int SETTLE = BL + (1 << CW) + 2;
  localparam int MAXD   = BL + (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din = 1'b0;
  logic          en_n = 1'b0;
  logic [CW-1:0] code = '0;
  logic          q, qn;

  int    checks = 0, errors = 0, edge_n = 0, cur_code = 0, last_chg = 0;
  bit    auto_chk = 1'b0;
  string tag = "R3";
  logic  hist [HLEN];

  always #4 clk = ~clk;

  prog_delay_line #(.CODE_W(CW), .BASE_LAT(BL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .code_i(code),
    .en_ni(en_n), .q_o(q), .qn_o(qn)
  );

  function automatic logic exp_q(input int m);
    int idx;
    idx = m - (BL + cur_code - 1);
    if (idx < 1) return 1'b0;
    return hist[idx % HLEN];
  endfunction

  task automatic chk(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at edge %0d", req, act, expv, edge_n);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cyc(input logic d, input logic e);
    din = d; en_n = e;
    @(posedge clk);
    edge_n++;
    hist[edge_n % HLEN] = e ? 1'b0 : d;
    @(negedge clk);
    if (auto_chk && (edge_n - last_chg > SETTLE)) begin
      chk(tag, q, exp_q(edge_n));
      chk("R7 complement", qn, ~q);
    end
  endtask

  task automatic set_code(input int c);
    code = CW'(c); cur_code = c; last_chg = edge_n;
  endtask

  task automatic measure(input int c, output int dly);
    int k;
    auto_chk = 1'b0;
    set_code(c);
    repeat (SETTLE) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    k = edge_n;
    dly = q ? 1 : -1;
    while (dly < 0 && (edge_n - k) < MAXD + 8) begin
      cyc(1'b0, 1'b0);
      if (q) dly = edge_n - k + 1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int d0, d1, k;
    void'($urandom(32'd2024));
    for (int i = 0; i < HLEN; i++) hist[i] = 1'b0;

    // R1: reset state, with data already high at the input
    din = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 q during reset", q, 1'b0);
    chk("R1 qn during reset", qn, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b0);
      chk("R1 q after release", q, 1'b0);
      chk("R1 qn after release", qn, 1'b1);
    end

    // R2, R4, R5: single-pulse delay measurements
    measure(0, d0);    chk_int("R2 delay at code 0", d0, BL);
    measure(1023, d0); chk_int("R4 delay at code 1023", d0, BL + 1023);
    measure(5, d0); measure(6, d1);
    chk_int("R5 step 5->6", d1 - d0, 1);
    chk_int("R3 delay at code 6", d1, BL + 6);
    measure(511, d0); measure(512, d1);
    chk_int("R5 step 511->512", d1 - d0, 1);
    chk_int("R3 delay at code 512", d1, BL + 512);

    // R6: gating appears only after the programmed delay (code 3)
    set_code(3);
    repeat (SETTLE) cyc(1'b1, 1'b0);
    chk("R6 output high before disable", q, 1'b1);
    cyc(1'b1, 1'b1);
    k = edge_n;
    for (int m = 0; m < BL + 3 + 3; m++) begin
      if (m > 0) cyc(1'b1, 1'b1);
      chk("R6 delayed gating", q, (edge_n >= k + BL + 3 - 1) ? 1'b0 : 1'b1);
    end

    // R9: long disable with code changes keeps the output low
    for (int i = 0; i < MAXD + 8; i++) begin
      if (i % 97 == 0) set_code(int'($urandom % 1024));
      cyc(($urandom % 2) != 0, 1'b1);
    end
    for (int i = 0; i < 100; i++) begin
      if (i % 10 == 0) set_code(int'($urandom % 1024));
      cyc(($urandom % 2) != 0, 1'b1);
      chk("R9 flushed output low", q, 1'b0);
      chk("R7 complement when flushed", qn, 1'b1);
    end

    // R3, R8: random data with sparse disables over several codes
    for (int i = 0; i < 10; i++) begin
      int c;
      c = (i == 0) ? 0 : (i == 1) ? 1023 : int'($urandom % 1024);
      set_code(c);
      tag = (c == 0) ? "R2" : (c == 1023) ? "R4" : "R3";
      if (i > 0) tag = {tag, " after code change R8"};
      auto_chk = 1'b1;
      repeat (SETTLE + 250) cyc(($urandom % 2) != 0, ($urandom % 8) == 0);
      auto_chk = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule